// File: doc/BRIEF.md
# Indexed Display Memory Access Port

This block gives a host processor byte access to a display memory through four small registers instead of a full address bus. The host uses a 4-bit register select, an 8-bit data bus, an active-low I/O chip select and active-low write and read strobes. To reach the memory, the host first loads a 14-bit pointer through two pointer registers, one for the low byte and one for the high bits. It then reads or writes the window register. Each completed window access moves one byte at the pointer and advances the pointer by one. Runs of consecutive bytes therefore need the pointer loaded only once.

A control register holds a display-on bit. While that bit is set, the window is closed and the pointer does not move. The same register also carries a self-clearing software reset. The host strobes are asynchronous. Each strobe is gated by the chip select and passed through a synchronizer into the local clock domain. An access sequencer then runs it through these states: S_IDLE (waiting), S_RD_FETCH (latch the selected register or memory byte), S_RD_HOLD (drive read data until the strobe is released), S_RD_DONE (advance the pointer after a window read), S_WR_HOLD (sample the host data while the strobe is low) and S_WR_COMMIT (apply the write). The transitions are: S_IDLE to S_RD_FETCH when a read starts; S_RD_FETCH to S_RD_HOLD unconditionally; S_RD_HOLD to S_RD_DONE when the read strobe is released; S_RD_DONE to S_IDLE. For writes, S_IDLE goes to S_WR_HOLD when a write starts; S_WR_HOLD goes to S_WR_COMMIT when the write strobe is released; S_WR_COMMIT goes to S_IDLE. A read start takes priority over a write start. The on-chip memory model holds 2^RAM_AW bytes.

Top module: `vram_index_port`

## Requirements
- R1: Register select 0 is the pointer low byte, 1 the pointer high bits, 2 the data window and 3 the control register. In the control register, bit 0 is display-on and reads back. Bit 7 written as 1 is a software reset, and bit 7 reads as 0.
- R2: The pointer is 14 bits wide: bits 7:0 come from the low register and bits 13:8 from bits 5:0 of the high register. Bits 7:6 of a high write are ignored and read back as 0.
- R3: A write to either pointer register leaves the other part of the pointer unchanged.
- R4: With display-on at 0, a window write stores the byte at the pointer and then advances the pointer by one.
- R5: With display-on at 0, a window read returns the byte at the pointer and advances the pointer by one when the strobe is released. Repeated reads walk consecutive addresses.
- R6: host_doe is high and host_dout is valid no later than 5 clock cycles after rd_n falls with io_cs_n low. Both hold until the strobe is released. There is no wait signal. Outside a read, host_dout is 0.
- R7: With display-on at 1, window writes are discarded, window reads return 0x00, and the pointer does not advance.
- R8: rst_n low, or the software reset, clears the whole pointer and sets display-on to 0.
- R9: Advancing from 0x3FFF wraps the pointer to 0x0000.
- R10: Selects 4 to 15 read as 0x00, and writes to them change no state.
- R11: The memory holds 2^RAM_AW bytes (2048 by default) and is addressed by the low RAM_AW pointer bits, so pointers 0x0005 and 0x0805 reach the same byte.
- R12: Strobes asserted while io_cs_n is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| io_cs_n | input | 1 | Active-low I/O chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| host_sel | input | 4 | Register select |
| host_din | input | 8 | Write data from the host |
| host_dout | output | 8 | Read data to the host |
| host_doe | output | 1 | High while host_dout carries read data |
| disp_on | output | 1 | Display-on bit of the control register |

## Verification
The bench targets the pointer boundaries. It checks the wrap from 0x3FFF, where a design with a wider or saturating counter would read back a wrong pointer, and the high-register mask, where a design that stored bits 7:6 would return them. It checks that each pointer register loads on its own, since a design that reloaded the whole pointer would clobber the other half. It also checks that a window access with display-on set leaves both the memory and the pointer untouched. Finally, it checks that the software reset and unused selects behave as specified, and that memory aliasing at 0x0805 and the read latency match, so that an off-by-one in the increment timing shows up as a wrong byte.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;
    localparam int SEL_W  = 4;
    localparam int DATA_W = 8;

    localparam logic [SEL_W-1:0] SEL_PTR_LO = 4'd0;
    localparam logic [SEL_W-1:0] SEL_PTR_HI = 4'd1;
    localparam logic [SEL_W-1:0] SEL_WINDOW = 4'd2;
    localparam logic [SEL_W-1:0] SEL_CTRL   = 4'd3;

    localparam int CTRL_DISP_BIT = 0;
    localparam int CTRL_SRST_BIT = 7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_FETCH,
        S_RD_HOLD,
        S_RD_DONE,
        S_WR_HOLD,
        S_WR_COMMIT
    } acc_state_t;
endpackage

// File: rtl/vram_strobe_sync.sv
module vram_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], async_in};
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/vram_pointer.sv
module vram_pointer #(
    parameter int PTR_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic             inc,
    input  logic             clr,
    input  logic [7:0]       din,
    output logic [PTR_W-1:0] ptr
);
    localparam int HI_W = PTR_W - 8;
    localparam logic [PTR_W-1:0] PTR_MAX = {PTR_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clr) begin
            ptr <= '0;
        end else if (ld_lo) begin
            ptr[7:0] <= din;
        end else if (ld_hi) begin
            ptr[PTR_W-1:8] <= din[HI_W-1:0];
        end else if (inc) begin
            ptr <= ptr + 1'b1;
        end
    end

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !ld_lo && !ld_hi) |=> ptr == $past(ptr) + 1'b1);
    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !ld_lo && !ld_hi && ptr == PTR_MAX) |=> ptr == '0);
    p_lo_keeps_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_lo && !clr) |=> ptr[PTR_W-1:8] == $past(ptr[PTR_W-1:8]));
    p_hi_keeps_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hi && !clr && !ld_lo) |=> ptr[7:0] == $past(ptr[7:0]));
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ptr == '0);
endmodule

// File: rtl/vram_store.sv
module vram_store #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/vram_access_fsm.sv
module vram_access_fsm
    import vram_port_pkg::*;
#(
    parameter int PTR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_level,
    input  logic              rd_start,
    input  logic              wr_level,
    input  logic              wr_start,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic [7:0]        host_din,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [7:0]        mem_q,
    output logic              ptr_ld_lo,
    output logic              ptr_ld_hi,
    output logic              ptr_inc,
    output logic              ptr_clr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic [7:0]        host_dout,
    output logic              host_doe,
    output logic              disp_on
);
    localparam int HI_W = PTR_W - 8;

    acc_state_t           state, state_nx;
    logic [SEL_W-1:0]     sel_q;
    logic [7:0]           din_q;
    logic [7:0]           dout_q;
    logic                 disp_q;
    logic                 disp_set, disp_clr;
    logic [7:0]           rd_mux;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (rd_start)      state_nx = S_RD_FETCH;
                else if (wr_start) state_nx = S_WR_HOLD;
            end
            S_RD_FETCH:  state_nx = S_RD_HOLD;
            S_RD_HOLD:   if (!rd_level) state_nx = S_RD_DONE;
            S_RD_DONE:   state_nx = S_IDLE;
            S_WR_HOLD:   if (!wr_level) state_nx = S_WR_COMMIT;
            S_WR_COMMIT: state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // read data selection
    always_comb begin
        rd_mux = 8'h00;
        unique case (sel_q)
            SEL_PTR_LO: rd_mux = ptr[7:0];
            SEL_PTR_HI: rd_mux = {{(8-HI_W){1'b0}}, ptr[PTR_W-1:8]};
            SEL_WINDOW: rd_mux = disp_q ? 8'h00 : mem_q;
            SEL_CTRL:   rd_mux = {7'b0, disp_q};
            default:    rd_mux = 8'h00;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        ptr_ld_lo = 1'b0;
        ptr_ld_hi = 1'b0;
        ptr_inc   = 1'b0;
        ptr_clr   = 1'b0;
        mem_we    = 1'b0;
        disp_set  = 1'b0;
        disp_clr  = 1'b0;
        unique case (state)
            S_RD_DONE: begin
                if (sel_q == SEL_WINDOW && !disp_q) ptr_inc = 1'b1;
            end
            S_WR_COMMIT: begin
                unique case (sel_q)
                    SEL_PTR_LO: ptr_ld_lo = 1'b1;
                    SEL_PTR_HI: ptr_ld_hi = 1'b1;
                    SEL_WINDOW: begin
                        if (!disp_q) begin
                            mem_we  = 1'b1;
                            ptr_inc = 1'b1;
                        end
                    end
                    SEL_CTRL: begin
                        if (din_q[CTRL_SRST_BIT]) begin
                            ptr_clr  = 1'b1;
                            disp_clr = 1'b1;
                        end else if (din_q[CTRL_DISP_BIT]) begin
                            disp_set = 1'b1;
                        end else begin
                            disp_clr = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            din_q  <= '0;
            dout_q <= '0;
            disp_q <= 1'b0;
        end else begin
            if (state == S_IDLE && (rd_start || wr_start)) sel_q <= host_sel;
            if (state == S_WR_HOLD) din_q <= host_din;
            if (state == S_RD_FETCH) dout_q <= rd_mux;
            else if (state == S_RD_DONE) dout_q <= 8'h00;
            if (disp_clr)      disp_q <= 1'b0;
            else if (disp_set) disp_q <= 1'b1;
        end
    end

    assign mem_wdata = din_q;
    assign host_doe  = (state == S_RD_HOLD);
    assign host_dout = host_doe ? dout_q : 8'h00;
    assign disp_on   = disp_q;

    p_dout_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD_HOLD && $past(state) == S_RD_HOLD) |-> $stable(host_dout));
    p_quiet_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_doe |-> host_dout == 8'h00);
    p_one_ptr_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ptr_ld_lo, ptr_ld_hi, ptr_inc, ptr_clr}));
    p_srst_clears_disp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> !disp_q);
endmodule

// File: rtl/vram_index_port.sv
module vram_index_port
    import vram_port_pkg::*;
#(
    parameter int PTR_W       = 14,
    parameter int RAM_AW      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic [SEL_W-1:0] host_sel,
    input  logic [7:0]       host_din,
    output logic [7:0]       host_dout,
    output logic             host_doe,
    output logic             disp_on
);
    localparam int N_STROBE = 2;

    logic [N_STROBE-1:0] strobe_act, strobe_lvl, strobe_rise;
    logic [PTR_W-1:0]    ptr;
    logic                ptr_ld_lo, ptr_ld_hi, ptr_inc, ptr_clr;
    logic                mem_we;
    logic [7:0]          mem_wdata, mem_q;

    // index 0: read, index 1: write; gated by chip select (R12)
    assign strobe_act[0] = ~io_cs_n & ~rd_n;
    assign strobe_act[1] = ~io_cs_n & ~wr_n;

    for (genvar g = 0; g < N_STROBE; g++) begin : g_sync
        vram_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (strobe_act[g]),
            .level    (strobe_lvl[g]),
            .rise     (strobe_rise[g])
        );
    end

    vram_access_fsm #(.PTR_W(PTR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_level  (strobe_lvl[0]),
        .rd_start  (strobe_rise[0]),
        .wr_level  (strobe_lvl[1]),
        .wr_start  (strobe_rise[1]),
        .host_sel  (host_sel),
        .host_din  (host_din),
        .ptr       (ptr),
        .mem_q     (mem_q),
        .ptr_ld_lo (ptr_ld_lo),
        .ptr_ld_hi (ptr_ld_hi),
        .ptr_inc   (ptr_inc),
        .ptr_clr   (ptr_clr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .host_dout (host_dout),
        .host_doe  (host_doe),
        .disp_on   (disp_on)
    );

    vram_pointer #(.PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_lo (ptr_ld_lo),
        .ld_hi (ptr_ld_hi),
        .inc   (ptr_inc),
        .clr   (ptr_clr),
        .din   (mem_wdata),
        .ptr   (ptr)
    );

    vram_store #(.AW(RAM_AW)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .addr  (ptr[RAM_AW-1:0]),
        .wdata (mem_wdata),
        .rdata (mem_q)
    );

    p_gate_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !disp_on);
    p_no_move_when_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_on && !ptr_ld_lo && !ptr_ld_hi && !ptr_clr) |=> ptr == $past(ptr));
    p_idle_without_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (io_cs_n && $past(io_cs_n) && $past(io_cs_n, 2) && $past(io_cs_n, 3)) |-> !mem_we);
endmodule

// File: tb/vram_index_port_tb_top.sv
module vram_index_port_tb_top;
    localparam time CLK_P = 4ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [3:0] host_sel = '0;
    logic [7:0] host_din = '0;
    logic [7:0] host_dout;
    logic       host_doe, disp_on;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    vram_index_port dut_i (
        .clk(clk), .rst_n(rst_n), .io_cs_n(io_cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .host_sel(host_sel), .host_din(host_din), .host_dout(host_dout),
        .host_doe(host_doe), .disp_on(disp_on)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [3:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_sel = sel; host_din = d; io_cs_n = 1'b0;
        @(negedge clk); wr_n = 1'b0;
        repeat (5) @(negedge clk);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        io_cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic host_rd(input logic [3:0] sel, output logic [7:0] d, output logic oe);
        @(negedge clk);
        host_sel = sel; io_cs_n = 1'b0;
        @(negedge clk); rd_n = 1'b0;
        repeat (5) @(negedge clk);
        d = host_dout; oe = host_doe;
        rd_n = 1'b1;
        repeat (5) @(negedge clk);
        io_cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_ptr(input logic [13:0] p);
        host_wr(4'd0, p[7:0]);
        host_wr(4'd1, {2'b00, p[13:8]});
    endtask

    task automatic expect_ptr(input string req, input logic [13:0] p);
        logic [7:0] lo, hi; logic oe;
        host_rd(4'd0, lo, oe);
        host_rd(4'd1, hi, oe);
        check(req, {hi, lo}, {2'b00, p});
    endtask

    task automatic t_reset;
        logic [7:0] d; logic oe;
        check("R6 idle bus", {host_doe, host_dout}, 0);
        expect_ptr("R8 reset pointer", 14'h0);
        host_rd(4'd3, d, oe);
        check("R8 reset display-on", d, 0);
        check("R8 disp_on port", disp_on, 0);
    endtask

    task automatic t_pointer_regs;
        host_wr(4'd0, 8'hA5);
        host_wr(4'd1, 8'hFF);
        expect_ptr("R2 pointer load with mask", 14'h3FA5);
        host_wr(4'd0, 8'h12);
        expect_ptr("R3 low write keeps high", 14'h3F12);
        host_wr(4'd1, 8'h05);
        expect_ptr("R3 high write keeps low", 14'h0512);
    endtask

    task automatic t_window_walk;
        logic [7:0] d; logic oe;
        set_ptr(14'h0010);
        for (int i = 0; i < 3; i++) host_wr(4'd2, 8'h40 + 8'(i));
        expect_ptr("R4 write advance", 14'h0013);
        set_ptr(14'h0010);
        for (int i = 0; i < 3; i++) begin
            host_rd(4'd2, d, oe);
            check("R5 sequential read", d, 8'h40 + i);
            check("R6 output enable in time", oe, 1);
        end
        expect_ptr("R5 read advance", 14'h0013);
    endtask

    task automatic t_wrap;
        logic [7:0] d; logic oe;
        set_ptr(14'h3FFF);
        host_wr(4'd2, 8'h9C);
        expect_ptr("R9 wrap on write", 14'h0000);
        set_ptr(14'h3FFF);
        host_rd(4'd2, d, oe);
        check("R9 byte at top", d, 8'h9C);
        expect_ptr("R9 wrap on read", 14'h0000);
    endtask

    task automatic t_alias;
        logic [7:0] d; logic oe;
        set_ptr(14'h0005);
        host_wr(4'd2, 8'h77);
        set_ptr(14'h0805);
        host_rd(4'd2, d, oe);
        check("R11 alias", d, 8'h77);
    endtask

    task automatic t_display_on;
        logic [7:0] d; logic oe;
        set_ptr(14'h0020);
        host_wr(4'd2, 8'h11);
        host_wr(4'd3, 8'h01);
        host_rd(4'd3, d, oe);
        check("R1 control readback", d, 8'h01);
        check("R1 disp_on port", disp_on, 1);
        set_ptr(14'h0020);
        host_wr(4'd2, 8'hEE);
        expect_ptr("R7 no advance on write", 14'h0020);
        host_rd(4'd2, d, oe);
        check("R7 read returns zero", d, 0);
        expect_ptr("R7 no advance on read", 14'h0020);
        host_wr(4'd3, 8'h00);
        host_rd(4'd2, d, oe);
        check("R7 write discarded", d, 8'h11);
    endtask

    task automatic t_unused_and_cs;
        logic [7:0] d; logic oe;
        set_ptr(14'h0101);
        host_wr(4'd5, 8'hFF);
        host_wr(4'd15, 8'h01);
        host_rd(4'd9, d, oe);
        check("R10 unused reads zero", d, 0);
        expect_ptr("R10 unused write ignored", 14'h0101);
        check("R10 control untouched", disp_on, 0);
        @(negedge clk);
        host_sel = 4'd2; host_din = 8'h5A;
        wr_n = 1'b0; repeat (5) @(negedge clk); wr_n = 1'b1;
        repeat (3) @(negedge clk);
        rd_n = 1'b0; repeat (5) @(negedge clk);
        check("R12 no output without cs", host_doe, 0);
        rd_n = 1'b1; repeat (3) @(negedge clk);
        expect_ptr("R12 pointer unchanged", 14'h0101);
    endtask

    task automatic t_soft_reset;
        logic [7:0] d; logic oe;
        set_ptr(14'h2ABC);
        host_wr(4'd3, 8'h01);
        host_wr(4'd3, 8'h81);
        expect_ptr("R8 soft reset pointer", 14'h0);
        host_rd(4'd3, d, oe);
        check("R1 R8 control after soft reset", d, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_pointer_regs();
        t_window_walk();
        t_wrap();
        t_alias();
        t_display_on();
        t_unused_and_cs();
        t_soft_reset();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule